// File: doc/BRIEF.md
# Macroblock Input Request Sequencer

This block runs the pixel input side of a block-based video encoder. A rising edge on the frame-start input restarts it. After a fixed lead-in it asks the upstream source for one macroblock per slot by raising a request line for a bounded window. During that window it takes 8-bit pixels on a single-cycle strobe and tags each accepted byte with its sub-block and in-block pixel position. It also numbers every macroblock with a group-of-blocks index and a macroblock index inside that group.

Each slot has a fixed length, so requests recur at a fixed minimum spacing. In full-resolution (CIF) mode one idle slot with no request is placed after every macroblock row except the last one. Quarter-resolution (QCIF) mode uses fewer groups and inserts no idle slots. At the close of each window the block pulses a completion strobe. It flags a short macroblock and keeps sticky flags for short windows (underrun) and for bytes it refused (overrun). Once the last macroblock of the frame is done, the block stays idle until the next frame start. The mode input is sampled on the frame-start edge.

Top module: `mbreq_seq`

## Requirements
- R1: The clock edge that samples `frame_i` high after a low sample starts a new frame from any state. It latches `cif_i` (1 = CIF, 0 = QCIF), clears both sticky flags, sets the numbers to group 1 / macroblock 1 and drops any request in progress.
- R2: The first request of a frame rises exactly LEAD clocks after the frame-start edge.
- R3: Every request stays high for exactly WIN consecutive clocks.
- R4: Within a macroblock row, successive request rises are exactly SLOT clocks apart.
- R5: A byte with `pix_valid_i` high, while the request is high and the macroblock is not yet full, is accepted. One clock later `pix_we_o` is high and `pix_data_o` holds the byte. `pix_blk_o` gives its sub-block: 0 to 3 are luminance, 4 is U and 5 is V. `pix_idx_o` gives its raster index inside the sub-block. The pixel index runs first, then the sub-block.
- R6: A byte offered while the request is low, or after all BLKS*PIX bytes of the macroblock have been taken, causes no `pix_we_o`. It sets sticky `overrun_o` one clock later.
- R7: `mb_done_o` is high for exactly one clock, the first clock after the request falls. During that clock `gob_num_o` and `mb_num_o` name the macroblock of that slot, and `mb_short_o` is high exactly when fewer than BLKS*PIX bytes were accepted.
- R8: A short window sets sticky `underrun_o` one clock after `mb_done_o`. The next macroblock still starts at sub-block 0, pixel 0.
- R9: `mb_num_o` counts from 1 up to COLS*ROWS inside a group, then returns to 1 while `gob_num_o` steps up by one from 1.
- R10: In CIF mode, one slot with no request follows each row of COLS macroblocks, except the frame's last row, so the request rise after a row end comes 2*SLOT clocks after the previous one. QCIF mode never inserts such a slot.
- R11: A frame holds GOBS_CIF or GOBS_QCIF groups of ROWS*COLS macroblocks. After the last one, the request and `mb_done_o` stay low until the next frame start. They are also low after reset, before any frame start.
- R12: A frame start in the middle of a frame abandons it. The next request comes LEAD clocks later and carries group 1 / macroblock 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame-start level; its rising edge starts a frame |
| cif_i | input | 1 | 1 = CIF, 0 = QCIF, sampled at frame start |
| pix_valid_i | input | 1 | Single-cycle pixel strobe |
| pix_data_i | input | DW | Pixel byte |
| req_o | output | 1 | Request for macroblock data |
| pix_we_o | output | 1 | Accepted-byte strobe |
| pix_data_o | output | DW | Accepted byte |
| pix_blk_o | output | clog2(BLKS) | Sub-block of accepted byte |
| pix_idx_o | output | clog2(PIX) | Raster index of accepted byte |
| mb_done_o | output | 1 | End-of-slot strobe for a real macroblock |
| mb_short_o | output | 1 | Macroblock closed incomplete |
| gob_num_o | output | clog2(GOBS_CIF+1) | Group number, from 1 |
| mb_num_o | output | clog2(COLS*ROWS+1) | Macroblock number in group, from 1 |
| underrun_o | output | 1 | Sticky short-window flag |
| overrun_o | output | 1 | Sticky refused-byte flag |

## Verification
The bench runs whole QCIF and CIF frames and checks every request rise time against a schedule built from the slot rules. This separates plain slot spacing from the doubled spacing after a CIF row, and it shows where the group number changes. Full macroblocks fed at half clock rate test the sub-block and pixel tagging of every byte. A macroblock cut short, and one given a surplus byte plus a stray byte in the gap, tell apart the underrun path, the full-block refusal and the idle refusal. A frame start given mid-frame shows that timing and numbering restart rather than carry on.

// File: rtl/mbreq_pkg.sv
package mbreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SLOT  = 2'd2,
    ST_DUMMY = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mbreq_slot_timer.sv
module mbreq_slot_timer
  import mbreq_pkg::*;
#(
  parameter int LEAD = 184,
  parameter int WIN  = 1871,
  parameter int SLOT = 2064
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frm_start_i,
  input  logic cif_i,
  input  logic row_last_i,
  input  logic frame_last_i,
  output logic req_o,
  output logic win_close_o,
  output logic slot_end_o
);
  localparam int CMAX = (LEAD > SLOT) ? LEAD : SLOT;
  localparam int CW   = $clog2(CMAX + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (frm_start_i) begin
      state_q <= ST_LEAD;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_LEAD: begin
          if (cnt_q == CW'(LEAD - 1)) begin
            state_q <= ST_SLOT;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SLOT: begin
          if (cnt_q == CW'(SLOT - 1)) begin
            cnt_q <= '0;
            if (frame_last_i)            state_q <= ST_IDLE;
            else if (row_last_i && cif_i) state_q <= ST_DUMMY;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DUMMY: begin
          if (cnt_q == CW'(SLOT - 1)) begin
            state_q <= ST_SLOT;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign req_o       = (state_q == ST_SLOT) && (cnt_q < CW'(WIN));
  assign win_close_o = (state_q == ST_SLOT) && (cnt_q == CW'(WIN));
  assign slot_end_o  = (state_q == ST_SLOT) && (cnt_q == CW'(SLOT - 1));
endmodule

// File: rtl/mbreq_numbering.sv
module mbreq_numbering #(
  parameter int COLS      = 11,
  parameter int ROWS      = 3,
  parameter int GOBS_CIF  = 12,
  parameter int GOBS_QCIF = 3,
  parameter int GW        = $clog2(GOBS_CIF + 1),
  parameter int MW        = $clog2(COLS * ROWS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frm_start_i,
  input  logic          cif_i,
  input  logic          slot_end_i,
  output logic [GW-1:0] gob_o,
  output logic [MW-1:0] mb_o,
  output logic          row_last_o,
  output logic          frame_last_o
);
  localparam int XW = $clog2(COLS + 1);
  localparam int YW = $clog2(ROWS + 1);

  logic [XW-1:0] col_q;
  logic [YW-1:0] row_q;
  logic [GW-1:0] gob_q, gob_max;
  logic [MW-1:0] mb_q;
  logic          row_end, gob_end;

  assign gob_max      = cif_i ? GW'(GOBS_CIF) : GW'(GOBS_QCIF);
  assign row_end      = (col_q == XW'(COLS - 1));
  assign gob_end      = row_end && (row_q == YW'(ROWS - 1));
  assign row_last_o   = row_end;
  assign frame_last_o = gob_end && (gob_q == gob_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      gob_q <= GW'(1);
      mb_q  <= MW'(1);
    end else if (frm_start_i) begin
      col_q <= '0;
      row_q <= '0;
      gob_q <= GW'(1);
      mb_q  <= MW'(1);
    end else if (slot_end_i && !frame_last_o) begin
      if (gob_end) begin
        col_q <= '0;
        row_q <= '0;
        gob_q <= gob_q + 1'b1;
        mb_q  <= MW'(1);
      end else begin
        mb_q <= mb_q + 1'b1;
        if (row_end) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else col_q <= col_q + 1'b1;
      end
    end
  end

  assign gob_o = gob_q;
  assign mb_o  = mb_q;
endmodule

// File: rtl/mbreq_capture.sv
module mbreq_capture #(
  parameter int DW   = 8,
  parameter int PIX  = 64,
  parameter int BLKS = 6,
  parameter int PW   = $clog2(PIX),
  parameter int BW   = $clog2(BLKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frm_start_i,
  input  logic          req_i,
  input  logic          win_close_i,
  input  logic          pix_valid_i,
  input  logic [DW-1:0] pix_data_i,
  output logic          we_o,
  output logic [DW-1:0] data_o,
  output logic [BW-1:0] blk_o,
  output logic [PW-1:0] idx_o,
  output logic          full_o,
  output logic          underrun_o,
  output logic          overrun_o
);
  logic [PW-1:0] pix_q;
  logic [BW-1:0] blk_q;
  logic          full_q, accept;

  assign accept = pix_valid_i && req_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q      <= '0;
      blk_q      <= '0;
      full_q     <= 1'b0;
      underrun_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else if (frm_start_i) begin
      pix_q      <= '0;
      blk_q      <= '0;
      full_q     <= 1'b0;
      underrun_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      if (pix_valid_i && !accept) overrun_o <= 1'b1;
      if (win_close_i) begin
        if (!full_q) underrun_o <= 1'b1;
        pix_q  <= '0;
        blk_q  <= '0;
        full_q <= 1'b0;
      end else if (accept) begin
        if (pix_q == PW'(PIX - 1)) begin
          pix_q <= '0;
          if (blk_q == BW'(BLKS - 1)) begin
            blk_q  <= '0;
            full_q <= 1'b1;
          end else blk_q <= blk_q + 1'b1;
        end else pix_q <= pix_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      data_o <= '0;
      blk_o  <= '0;
      idx_o  <= '0;
    end else begin
      we_o <= accept;
      if (accept) begin
        data_o <= pix_data_i;
        blk_o  <= blk_q;
        idx_o  <= pix_q;
      end
    end
  end

  assign full_o = full_q;
endmodule

// File: rtl/mbreq_seq.sv
module mbreq_seq #(
  parameter int DW        = 8,
  parameter int LEAD      = 184,
  parameter int WIN       = 1871,
  parameter int SLOT      = 2064,
  parameter int PIX       = 64,
  parameter int BLKS      = 6,
  parameter int COLS      = 11,
  parameter int ROWS      = 3,
  parameter int GOBS_CIF  = 12,
  parameter int GOBS_QCIF = 3,
  localparam int PW       = $clog2(PIX),
  localparam int BW       = $clog2(BLKS),
  localparam int GW       = $clog2(GOBS_CIF + 1),
  localparam int MW       = $clog2(COLS * ROWS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          cif_i,
  input  logic          pix_valid_i,
  input  logic [DW-1:0] pix_data_i,
  output logic          req_o,
  output logic          pix_we_o,
  output logic [DW-1:0] pix_data_o,
  output logic [BW-1:0] pix_blk_o,
  output logic [PW-1:0] pix_idx_o,
  output logic          mb_done_o,
  output logic          mb_short_o,
  output logic [GW-1:0] gob_num_o,
  output logic [MW-1:0] mb_num_o,
  output logic          underrun_o,
  output logic          overrun_o
);
  logic frame_q, cif_q, frm_start;
  logic row_last, frame_last, slot_end, win_close, full;

  assign frm_start = frame_i && !frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      cif_q   <= 1'b0;
    end else begin
      frame_q <= frame_i;
      if (frm_start) cif_q <= cif_i;
    end
  end

  mbreq_slot_timer #(.LEAD(LEAD), .WIN(WIN), .SLOT(SLOT)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frm_start_i  (frm_start),
    .cif_i        (cif_q),
    .row_last_i   (row_last),
    .frame_last_i (frame_last),
    .req_o        (req_o),
    .win_close_o  (win_close),
    .slot_end_o   (slot_end)
  );

  mbreq_numbering #(
    .COLS(COLS), .ROWS(ROWS), .GOBS_CIF(GOBS_CIF), .GOBS_QCIF(GOBS_QCIF),
    .GW(GW), .MW(MW)
  ) u_num (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frm_start_i  (frm_start),
    .cif_i        (cif_q),
    .slot_end_i   (slot_end),
    .gob_o        (gob_num_o),
    .mb_o         (mb_num_o),
    .row_last_o   (row_last),
    .frame_last_o (frame_last)
  );

  mbreq_capture #(.DW(DW), .PIX(PIX), .BLKS(BLKS), .PW(PW), .BW(BW)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frm_start_i (frm_start),
    .req_i       (req_o),
    .win_close_i (win_close),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .we_o        (pix_we_o),
    .data_o      (pix_data_o),
    .blk_o       (pix_blk_o),
    .idx_o       (pix_idx_o),
    .full_o      (full),
    .underrun_o  (underrun_o),
    .overrun_o   (overrun_o)
  );

  assign mb_done_o  = win_close;
  assign mb_short_o = win_close && !full;
endmodule

// File: rtl/mbreq_seq_chk.sv
module mbreq_seq_chk #(
  parameter int WIN  = 1871,
  parameter int BLKS = 6,
  parameter int BW   = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_i,
  input logic          pix_valid_i,
  input logic          req_o,
  input logic          pix_we_o,
  input logic [BW-1:0] pix_blk_o,
  input logic          mb_done_o,
  input logic          mb_short_o,
  input logic          overrun_o
);
  localparam int RW = $clog2(WIN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (!req_o) run_q <= '0;
    else             run_q <= run_q + 1'b1;
  end

  // R3: request never longer than the window
  a_r3_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> run_q < RW'(WIN));

  a_r5_we_from_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_o |-> $past(pix_valid_i) && $past(req_o));

  a_r5_blk_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_o |-> pix_blk_o < BW'(BLKS));

  a_r6_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !frame_i |=> overrun_o);

  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_done_o |=> !mb_done_o);

  a_r7_done_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_done_o |-> $past(req_o) && !req_o);

  a_r7_short_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_short_o |-> mb_done_o);
endmodule

bind mbreq_seq mbreq_seq_chk #(.WIN(WIN), .BLKS(BLKS), .BW(BW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_i     (frame_i),
  .pix_valid_i (pix_valid_i),
  .req_o       (req_o),
  .pix_we_o    (pix_we_o),
  .pix_blk_o   (pix_blk_o),
  .mb_done_o   (mb_done_o),
  .mb_short_o  (mb_short_o),
  .overrun_o   (overrun_o)
);

// File: tb/mbreq_seq_test.sv
`timescale 1ns/1ps
module mbreq_seq_test;
  localparam int DW = 8, LEAD = 10, WIN = 60, SLOT = 80, PIX = 4, BLKS = 6;
  localparam int COLS = 3, ROWS = 2, GOBS_CIF = 2, GOBS_QCIF = 1;
  localparam int PW = $clog2(PIX), BW = $clog2(BLKS);
  localparam int GW = $clog2(GOBS_CIF + 1), MW = $clog2(COLS * ROWS + 1);
  localparam int MBB = PIX * BLKS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 1'b0, cif = 1'b0, pv = 1'b0;
  logic [DW-1:0] pd = '0;
  logic req, we, done, shrt, unr, ovr;
  logic [DW-1:0] dout;
  logic [BW-1:0] blk;
  logic [PW-1:0] idx;
  logic [GW-1:0] gob;
  logic [MW-1:0] mbn;
  int cyc = 0, n_chk = 0, n_err = 0, t0 = 0, last_rise = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbreq_seq #(
    .DW(DW), .LEAD(LEAD), .WIN(WIN), .SLOT(SLOT), .PIX(PIX), .BLKS(BLKS),
    .COLS(COLS), .ROWS(ROWS), .GOBS_CIF(GOBS_CIF), .GOBS_QCIF(GOBS_QCIF)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .cif_i(cif),
    .pix_valid_i(pv), .pix_data_i(pd), .req_o(req), .pix_we_o(we),
    .pix_data_o(dout), .pix_blk_o(blk), .pix_idx_o(idx), .mb_done_o(done),
    .mb_short_o(shrt), .gob_num_o(gob), .mb_num_o(mbn),
    .underrun_o(unr), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req_tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  function automatic logic [DW-1:0] pat(input int g, input int m, input int i);
    return DW'(g * 37 + m * 11 + i * 3);
  endfunction

  task automatic start_frame(input bit c);
    @(negedge clk);
    frame = 1'b1;
    cif = c;
    @(negedge clk);
    frame = 1'b0;
    t0 = cyc;
  endtask

  // one macroblock slot: rise time, byte tagging, window, done/short/underrun
  task automatic run_mb(input int eg, input int em, input int nb, input int exp_rise,
                        input bit extra, input bit exp_unr);
    int r;
    while (!req) @(negedge clk);
    r = cyc;
    chk(r == exp_rise, "R2/R4/R10 request rise", r, exp_rise);
    for (int i = 0; i < nb + (extra ? 1 : 0); i++) begin
      pv = 1'b1;
      pd = pat(eg, em, i);
      @(negedge clk);
      pv = 1'b0;
      if (i < MBB) begin
        chk(we == 1'b1 && dout == pat(eg, em, i), "R5 byte accepted", int'(dout), int'(pat(eg, em, i)));
        chk(int'(blk) == i / PIX && int'(idx) == i % PIX, "R5 position",
            int'(blk) * 100 + int'(idx), (i / PIX) * 100 + i % PIX);
      end else begin
        chk(we == 1'b0, "R6 byte past full ignored", int'(we), 0);
        chk(ovr == 1'b1, "R6 overrun on full", int'(ovr), 1);
      end
      @(negedge clk);
    end
    while (req) @(negedge clk);
    chk(cyc - r == WIN, "R3 window length", cyc - r, WIN);
    chk(done == 1'b1, "R7 done after window", int'(done), 1);
    chk(int'(gob) == eg, "R9 gob number", int'(gob), eg);
    chk(int'(mbn) == em, "R9 mb number", int'(mbn), em);
    chk(shrt == (nb < MBB), "R7 short flag", int'(shrt), int'(nb < MBB));
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
    chk(unr == exp_unr, "R8 underrun", int'(unr), int'(exp_unr));
    last_rise = r;
  endtask

  task automatic check_quiet(input int ncyc);
    int seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (req || done) seen++;
    end
    chk(seen == 0, "R11 quiet after frame", seen, 0);
  endtask

  task automatic full_frame(input bit c);
    int ng = c ? GOBS_CIF : GOBS_QCIF;
    int nxt;
    start_frame(c);
    nxt = t0 + LEAD;
    for (int g = 1; g <= ng; g++)
      for (int m = 1; m <= COLS * ROWS; m++) begin
        run_mb(g, m, MBB, nxt, 1'b0, 1'b0);
        nxt = last_rise + SLOT;
        if (c && (m % COLS == 0) && !(g == ng && m == COLS * ROWS)) nxt += SLOT;
      end
    check_quiet(3 * SLOT);
  endtask

  task automatic test_reset();
    chk(req == 1'b0 && done == 1'b0, "R11 reset idle", int'(req) + int'(done), 0);
    chk(unr == 1'b0 && ovr == 1'b0 && we == 1'b0, "R1 reset flags",
        int'(unr) + int'(ovr) + int'(we), 0);
    check_quiet(2 * SLOT);
  endtask

  task automatic test_short_and_overrun();
    start_frame(1'b0);
    chk(ovr == 1'b0 && unr == 1'b0, "R1 flags clear at frame", int'(ovr) + int'(unr), 0);
    run_mb(1, 1, MBB, t0 + LEAD, 1'b1, 1'b0);
    run_mb(1, 2, 10, last_rise + SLOT, 1'b0, 1'b1);
    run_mb(1, 3, MBB, last_rise + SLOT, 1'b0, 1'b1);
    // stray byte in gap while request is low
    @(negedge clk);
    pv = 1'b1;
    @(negedge clk);
    pv = 1'b0;
    chk(we == 1'b0, "R6 idle byte ignored", int'(we), 0);
    start_frame(1'b0);
    chk(ovr == 1'b0, "R1 overrun cleared", int'(ovr), 0);
    run_mb(1, 1, MBB, t0 + LEAD, 1'b0, 1'b0);
    @(negedge clk);
    pv = 1'b1;
    @(negedge clk);
    pv = 1'b0;
    chk(we == 1'b0 && ovr == 1'b1, "R6 idle byte sets overrun", int'(ovr), 1);
  endtask

  task automatic test_restart();
    start_frame(1'b1);
    run_mb(1, 1, MBB, t0 + LEAD, 1'b0, 1'b0);
    run_mb(1, 2, MBB, last_rise + SLOT, 1'b0, 1'b0);
    start_frame(1'b1);
    run_mb(1, 1, MBB, t0 + LEAD, 1'b0, 1'b0);
    chk(1'b1, "R12 restart numbering", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    full_frame(1'b0);
    full_frame(1'b1);
    test_short_and_overrun();
    test_restart();
    summary();
  end
endmodule